// File: doc/BRIEF.md
# Memory Controller Event Counter Unit

This block counts activity inside a DRAM controller for software that wants to measure it. It has a set of programmable counters and two fixed counters. Each programmable counter has a 64-bit configuration word. The low bits of that word form a mask over the event-strobe vector, and the top bit arms the counter. A programmable counter advances by one on every cycle where at least one strobe covered by its mask is high. It stops advancing once it reaches all ones.

A global run state gates all programmable counters. Software first selects manual mode. It then issues a begin command, which zeroes every programmable counter and starts counting, and later an end command, which freezes them and raises a done flag.

The two fixed counters count data-read and data-write beats. Each has its own enable bit and its own clear bit. They ignore the run state and wrap to zero past their top value, so software finds overflow by seeing a reading smaller than the one before it. All state is reached through one 64-bit register port: writes are synchronous and reads are combinational.

Top module: `mcev_monitor`

## Requirements
- R1: After reset, every register at the offsets listed below reads zero. This covers counter values, configuration words, the run flag, the done flag, the mode bit and the fixed enables.
- R2: The mode bit (offset 0x8020, bit 0) reads back as written. The fixed-enable bits (offset 0x80C0, bits 1:0) read back as written. Configuration word n (offset 0x8040 + 8·n) reads back its mask bits [EVT_W-1:0] and its arm bit 63; its other bits read zero.
- R3: A programmable counter (value at offset 0x8080 + 8·n) gains exactly one on a cycle where three conditions hold: its arm bit is set, the run flag is set, and the AND of its mask with the strobe vector is nonzero. Several matching strobes in one cycle still add only one, and a 4-bit mask group counts as one event.
- R4: A programmable counter holds its value while its arm bit is clear, while the run flag is clear, or when no masked strobe is high.
- R5: A programmable counter stays at 2^CNT_W−1 once it gets there.
- R6: Writing 1 to bit 0 of offset 0x8028 is the begin command. When manual mode is set and counting is not running, it zeroes all programmable counters and sets the run flag. The run flag reads at bit 1 of 0x8028. The command is ignored when manual mode is off, and also while counting is already running.
- R7: Writing 1 to bit 0 of offset 0x8030 is the end command. It clears the run flag and sets the done flag, which reads at bit 0 of 0x8038. Counter values are kept. A later begin command clears the done flag.
- R8: The write-beat counter (value at 0x80D0) counts while fixed-enable bit 0 is set. The read-beat counter (value at 0x80D8) counts while fixed-enable bit 1 is set. Neither depends on the run flag, and each wraps from 2^CNT_W−1 to zero.
- R9: At offset 0x80C8, writing bit 0 = 1 zeroes the write-beat counter and writing bit 1 = 1 zeroes the read-beat counter. A clear wins over a beat in the same cycle, and the offset itself reads zero.
- R10: A read from any other offset, or from a misaligned offset, returns zero. A write to such an offset changes no register, and the counter value offsets cannot be written.
- R11: A register write takes effect at the clock edge that ends the write cycle. A strobe in that same cycle is judged against the old configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data for bus_addr, combinational |
| evt_strobe | input | EVT_W | One strobe per controller event, high for each cycle the event occurs |
| dram_rd_beat | input | 1 | Data-read beat for the fixed read counter |
| dram_wr_beat | input | 1 | Data-write beat for the fixed write counter |

## Verification
A register write lands at the rising edge that ends its write cycle, and the read port shows the new value straight after that edge with no further delay. A strobe or beat held for n cycles adds n at the n edges it spans, and the sum is visible right after the last of those edges. The bench changes all inputs just after a falling edge and reads bus_rdata 1 ns after a later falling edge, so each expected value is taken a known whole number of edges after its stimulus. The bench narrows the counters to 5 bits so that saturation and wrap can be reached in a few dozen cycles.

// File: rtl/mcev_pkg.sv
package mcev_pkg;

   localparam int unsigned WORD_W      = 64;
   localparam int unsigned SLOT_STRIDE = 8;
   localparam int unsigned ARM_BIT     = 63;
   localparam int unsigned MAX_SLOTS   = 8;

   localparam logic [15:0] OFS_MODE  = 16'h8020;
   localparam logic [15:0] OFS_GO    = 16'h8028;
   localparam logic [15:0] OFS_HALT  = 16'h8030;
   localparam logic [15:0] OFS_DONE  = 16'h8038;
   localparam logic [15:0] OFS_CFG0  = 16'h8040;
   localparam logic [15:0] OFS_VAL0  = 16'h8080;
   localparam logic [15:0] OFS_FEN   = 16'h80C0;
   localparam logic [15:0] OFS_FCLR  = 16'h80C8;
   localparam logic [15:0] OFS_FWVAL = 16'h80D0;
   localparam logic [15:0] OFS_FRVAL = 16'h80D8;

   typedef struct packed {
      logic mode;
      logic go;
      logic halt;
      logic done;
      logic fen;
      logic fclr;
      logic fwval;
      logic frval;
   } glob_sel_t;

endpackage

// File: rtl/mcev_regdec.sv
module mcev_regdec
   import mcev_pkg::*;
#(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned NUM_PROG = 8
) (
   input  logic [ADDR_W-1:0]   addr,
   output glob_sel_t           gsel,
   output logic [NUM_PROG-1:0] cfg_sel,
   output logic [NUM_PROG-1:0] val_sel
);

   always_comb begin
      gsel.mode  = (addr == ADDR_W'(OFS_MODE));
      gsel.go    = (addr == ADDR_W'(OFS_GO));
      gsel.halt  = (addr == ADDR_W'(OFS_HALT));
      gsel.done  = (addr == ADDR_W'(OFS_DONE));
      gsel.fen   = (addr == ADDR_W'(OFS_FEN));
      gsel.fclr  = (addr == ADDR_W'(OFS_FCLR));
      gsel.fwval = (addr == ADDR_W'(OFS_FWVAL));
      gsel.frval = (addr == ADDR_W'(OFS_FRVAL));
   end

   for (genvar i = 0; i < NUM_PROG; i++) begin : g_slot
      assign cfg_sel[i] = (addr == ADDR_W'(32'(OFS_CFG0) + SLOT_STRIDE * i));
      assign val_sel[i] = (addr == ADDR_W'(32'(OFS_VAL0) + SLOT_STRIDE * i));
   end

endmodule

// File: rtl/mcev_run_ctl.sv
module mcev_run_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic mode_we,
   input  logic mode_d,
   input  logic go_cmd,
   input  logic halt_cmd,
   output logic manual,
   output logic running,
   output logic ended,
   output logic restart
);

   // a begin is honoured only in manual mode from the idle state
   assign restart = go_cmd & manual & ~running;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         manual  <= 1'b0;
         running <= 1'b0;
         ended   <= 1'b0;
      end else begin
         if (mode_we) manual <= mode_d;
         if (restart) begin
            running <= 1'b1;
            ended   <= 1'b0;
         end else if (halt_cmd) begin
            running <= 1'b0;
            ended   <= 1'b1;
         end
      end
   end

   assert_halt_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_cmd && !restart) |=> (!running && ended));

   assert_go_runs_R6: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (running && !ended));

   assert_run_needs_manual_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(running) |-> $past(manual));

endmodule

// File: rtl/mcev_prog_ctr.sv
module mcev_prog_ctr
   import mcev_pkg::*;
#(
   parameter int unsigned CNT_W = 49,
   parameter int unsigned EVT_W = 56
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [EVT_W-1:0]  mask_d,
   input  logic              arm_d,
   input  logic [EVT_W-1:0]  evt,
   input  logic              run,
   input  logic              clr,
   output logic [WORD_W-1:0] cfg_rd,
   output logic [CNT_W-1:0]  count
);

   logic [EVT_W-1:0] mask_q;
   logic             arm_q;
   logic             hit;
   logic             at_top;

   assign hit    = arm_q & run & (|(mask_q & evt));
   assign at_top = &count;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= '0;
         arm_q  <= 1'b0;
      end else if (cfg_we) begin
         mask_q <= mask_d;
         arm_q  <= arm_d;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                count <= '0;
      else if (clr)              count <= '0;
      else if (hit && !at_top)   count <= count + 1'b1;
   end

   always_comb begin
      cfg_rd              = '0;
      cfg_rd[EVT_W-1:0]   = mask_q;
      cfg_rd[ARM_BIT]     = arm_q;
   end

   assert_sat_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((&count) && !clr) |=> (&count));

   assert_step_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (count == $past(count) || count == $past(count) + 1'b1));

   assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !clr) |=> $stable(count));

   assert_restart_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (count == '0));

endmodule

// File: rtl/mcev_fixed_ctr.sv
module mcev_fixed_ctr #(
   parameter int unsigned CNT_W = 49
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             clr,
   input  logic             beat,
   output logic [CNT_W-1:0] count
);

   always_ff @(posedge clk) begin
      if (!rst_n)          count <= '0;
      else if (clr)        count <= '0;
      else if (en && beat) count <= count + 1'b1;
   end

   assert_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (en && beat && !clr && (&count)) |=> (count == '0));

   assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (count == '0));

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!(en && beat) && !clr) |=> $stable(count));

endmodule

// File: rtl/mcev_monitor.sv
module mcev_monitor
   import mcev_pkg::*;
#(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned NUM_PROG = 8,
   parameter int unsigned EVT_W    = 56,
   parameter int unsigned CNT_W    = 49
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [63:0]       bus_wdata,
   output logic [63:0]       bus_rdata,
   input  logic [EVT_W-1:0]  evt_strobe,
   input  logic              dram_rd_beat,
   input  logic              dram_wr_beat
);

   if (ADDR_W < 16) begin : g_chk_addr
      $error("mcev_monitor: ADDR_W must cover 16-bit offsets");
   end
   if (NUM_PROG < 1 || NUM_PROG > MAX_SLOTS) begin : g_chk_num
      $error("mcev_monitor: NUM_PROG must be 1..8");
   end
   if (EVT_W < 1 || EVT_W > ARM_BIT) begin : g_chk_evt
      $error("mcev_monitor: EVT_W must leave the arm bit free");
   end
   if (CNT_W < 2 || CNT_W > WORD_W - 1) begin : g_chk_cnt
      $error("mcev_monitor: CNT_W must be 2..63");
   end

   glob_sel_t              gsel;
   logic [NUM_PROG-1:0]    cfg_sel;
   logic [NUM_PROG-1:0]    val_sel;
   logic                   manual, running, ended, restart;
   logic                   go_cmd, halt_cmd;
   logic [1:0]             fen_q;
   logic                   fclr_wr, fclr_rd;
   logic [CNT_W-1:0]       wcnt, rcnt;
   logic [CNT_W-1:0]       pcount [NUM_PROG];
   logic [WORD_W-1:0]      pcfg   [NUM_PROG];
   logic                   unused_wdata;

   assign unused_wdata = ^bus_wdata;

   mcev_regdec #(.ADDR_W(ADDR_W), .NUM_PROG(NUM_PROG)) u_dec (
      .addr    (bus_addr),
      .gsel    (gsel),
      .cfg_sel (cfg_sel),
      .val_sel (val_sel)
   );

   assign go_cmd   = bus_wr & gsel.go   & bus_wdata[0];
   assign halt_cmd = bus_wr & gsel.halt & bus_wdata[0];
   assign fclr_wr  = bus_wr & gsel.fclr & bus_wdata[0];
   assign fclr_rd  = bus_wr & gsel.fclr & bus_wdata[1];

   mcev_run_ctl u_run (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_we  (bus_wr & gsel.mode),
      .mode_d   (bus_wdata[0]),
      .go_cmd   (go_cmd),
      .halt_cmd (halt_cmd),
      .manual   (manual),
      .running  (running),
      .ended    (ended),
      .restart  (restart)
   );

   for (genvar i = 0; i < NUM_PROG; i++) begin : g_prog
      mcev_prog_ctr #(.CNT_W(CNT_W), .EVT_W(EVT_W)) u_ctr (
         .clk    (clk),
         .rst_n  (rst_n),
         .cfg_we (bus_wr & cfg_sel[i]),
         .mask_d (bus_wdata[EVT_W-1:0]),
         .arm_d  (bus_wdata[ARM_BIT]),
         .evt    (evt_strobe),
         .run    (running),
         .clr    (restart),
         .cfg_rd (pcfg[i]),
         .count  (pcount[i])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                fen_q <= 2'b00;
      else if (bus_wr && gsel.fen) fen_q <= bus_wdata[1:0];
   end

   mcev_fixed_ctr #(.CNT_W(CNT_W)) u_wr_fix (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (fen_q[0]),
      .clr   (fclr_wr),
      .beat  (dram_wr_beat),
      .count (wcnt)
   );

   mcev_fixed_ctr #(.CNT_W(CNT_W)) u_rd_fix (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (fen_q[1]),
      .clr   (fclr_rd),
      .beat  (dram_rd_beat),
      .count (rcnt)
   );

   always_comb begin
      bus_rdata = '0;
      if (gsel.mode)  bus_rdata[0]         = manual;
      if (gsel.go)    bus_rdata[1]         = running;
      if (gsel.done)  bus_rdata[0]         = ended;
      if (gsel.fen)   bus_rdata[1:0]       = fen_q;
      if (gsel.fwval) bus_rdata[CNT_W-1:0] = wcnt;
      if (gsel.frval) bus_rdata[CNT_W-1:0] = rcnt;
      for (int i = 0; i < NUM_PROG; i++) begin
         if (cfg_sel[i]) bus_rdata            = pcfg[i];
         if (val_sel[i]) bus_rdata[CNT_W-1:0] = pcount[i];
      end
   end

   assert_fen_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && gsel.fen) |=> $stable(fen_q));

endmodule

// File: tb/mcev_monitor_bench.sv
module mcev_monitor_bench;

   localparam int CW = 5;
   localparam int EW = 56;
   localparam logic [63:0] TOP = 64'((1 << CW) - 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [15:0]   bus_addr = '0;
   logic [63:0]   bus_wdata = '0;
   logic [63:0]   bus_rdata;
   logic [EW-1:0] evt_strobe = '0;
   logic          dram_rd_beat = 1'b0;
   logic          dram_wr_beat = 1'b0;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   mcev_monitor #(.ADDR_W(16), .NUM_PROG(8), .EVT_W(EW), .CNT_W(CW)) u_mcev_monitor (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_wr       (bus_wr),
      .bus_addr     (bus_addr),
      .bus_wdata    (bus_wdata),
      .bus_rdata    (bus_rdata),
      .evt_strobe   (evt_strobe),
      .dram_rd_beat (dram_rd_beat),
      .dram_wr_beat (dram_wr_beat)
   );

   localparam int NT = 8;
   localparam logic [15:0] T_ADDR [NT] = '{16'h8040, 16'h8078, 16'h80C0, 16'h8020,
                                           16'h80C8, 16'h8100, 16'h8044, 16'h8080};
   localparam logic [63:0] T_DATA [NT] = '{64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0005,
                                           64'h0000_0000_0000_00FF, 64'h0000_0000_0000_0003,
                                           64'h0000_0000_0000_0000, 64'h0000_0000_0000_FFFF,
                                           64'h0000_0000_0000_0001, 64'h0000_0000_0000_001F};
   localparam logic [63:0] T_EXP  [NT] = '{64'h80FF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0005,
                                           64'h0000_0000_0000_0003, 64'h0000_0000_0000_0001,
                                           64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000,
                                           64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000};
   localparam string T_TAG [NT] = '{"R2", "R2", "R2", "R2", "R9", "R10", "R10", "R10"};

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [63:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a, output logic [63:0] v);
      @(negedge clk);
      bus_addr = a;
      #1;
      v = bus_rdata;
   endtask

   task automatic rdchk(input string tag, input logic [15:0] a, input logic [63:0] exp);
      logic [63:0] v;
      rd(a, v);
      chk(tag, v, exp);
   endtask

   task automatic strobe(input logic [EW-1:0] m, input logic rb, input logic wb, input int n);
      @(negedge clk);
      evt_strobe = m; dram_rd_beat = rb; dram_wr_beat = wb;
      repeat (n) @(negedge clk);
      evt_strobe = '0; dram_rd_beat = 1'b0; dram_wr_beat = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      do_reset();
      // R1 reset state
      rdchk("R1 cfg0", 16'h8040, 64'h0);
      rdchk("R1 val0", 16'h8080, 64'h0);
      rdchk("R1 run", 16'h8028, 64'h0);
      rdchk("R1 done", 16'h8038, 64'h0);
      rdchk("R1 mode", 16'h8020, 64'h0);
      rdchk("R1 wfix", 16'h80D0, 64'h0);
      rdchk("R1 fen", 16'h80C0, 64'h0);

      // table: write each vector then read it back
      for (int i = 0; i < NT; i++) begin
         wr(T_ADDR[i], T_DATA[i]);
         rdchk(T_TAG[i], T_ADDR[i], T_EXP[i]);
      end
      rdchk("R10 misaligned write left cfg0", 16'h8040, 64'h80FF_FFFF_FFFF_FFFF);

      do_reset();
      // R6: begin ignored outside manual mode
      wr(16'h8028, 64'h1);
      rdchk("R6 begin without manual", 16'h8028, 64'h0);

      wr(16'h8020, 64'h1);
      wr(16'h8040, 64'h8000_0000_0000_0001);
      wr(16'h8048, 64'h8000_0000_3C00_0000);
      wr(16'h8050, 64'h0000_0000_0000_0008);

      // R4: no count while not running
      strobe(56'h1, 1'b0, 1'b0, 3);
      rdchk("R4 idle run", 16'h8080, 64'h0);

      wr(16'h8028, 64'h1);
      rdchk("R6 run flag", 16'h8028, 64'h2);

      strobe(56'h9, 1'b0, 1'b0, 3);
      rdchk("R3 ctr0 count", 16'h8080, 64'd3);
      rdchk("R4 ctr2 unarmed", 16'h8090, 64'h0);
      rdchk("R4 ctr1 no match", 16'h8088, 64'h0);

      strobe(56'h1C00_0000, 1'b0, 1'b0, 2);
      rdchk("R3 multi-match one step", 16'h8088, 64'd2);
      strobe(56'h2000_0000, 1'b0, 1'b0, 1);
      rdchk("R3 group bit", 16'h8088, 64'd3);

      strobe(56'h1, 1'b0, 1'b0, 40);
      rdchk("R5 saturate", 16'h8080, TOP);

      // R11: configuration write and strobe in the same cycle
      @(negedge clk);
      evt_strobe = 56'h20;
      bus_wr = 1'b1; bus_addr = 16'h8058; bus_wdata = 64'h8000_0000_0000_0020;
      @(negedge clk);
      bus_wr = 1'b0;
      @(negedge clk);
      evt_strobe = '0;
      rdchk("R11 write then count", 16'h8098, 64'd1);

      // R7 end
      wr(16'h8030, 64'h1);
      rdchk("R7 done flag", 16'h8038, 64'h1);
      rdchk("R7 run cleared", 16'h8028, 64'h0);
      strobe(56'h0400_0000, 1'b0, 1'b0, 2);
      rdchk("R7 frozen value", 16'h8088, 64'd3);

      // R6 restart zeroes
      wr(16'h8028, 64'h1);
      rdchk("R6 restart zero ctr0", 16'h8080, 64'h0);
      rdchk("R6 restart zero ctr1", 16'h8088, 64'h0);
      rdchk("R7 done cleared", 16'h8038, 64'h0);
      strobe(56'h1, 1'b0, 1'b0, 2);
      wr(16'h8028, 64'h1);
      rdchk("R6 begin while running ignored", 16'h8080, 64'd2);

      // R8 fixed counters
      wr(16'h8030, 64'h1);
      strobe('0, 1'b1, 1'b1, 3);
      rdchk("R8 wfix disabled", 16'h80D0, 64'h0);
      rdchk("R8 rfix disabled", 16'h80D8, 64'h0);
      wr(16'h80C0, 64'h1);
      strobe('0, 1'b1, 1'b1, 4);
      rdchk("R8 wfix counts", 16'h80D0, 64'd4);
      rdchk("R8 rfix off", 16'h80D8, 64'h0);
      wr(16'h80C0, 64'h3);
      strobe('0, 1'b1, 1'b1, 30);
      rdchk("R8 wfix wraps", 16'h80D0, 64'd2);
      rdchk("R8 rfix no run needed", 16'h80D8, 64'd30);

      // R9 clear beats a simultaneous beat
      @(negedge clk);
      dram_rd_beat = 1'b1;
      bus_wr = 1'b1; bus_addr = 16'h80C8; bus_wdata = 64'h2;
      @(negedge clk);
      bus_wr = 1'b0; dram_rd_beat = 1'b0;
      rdchk("R9 rfix cleared", 16'h80D8, 64'h0);
      rdchk("R9 wfix untouched", 16'h80D0, 64'd2);
      wr(16'h80C8, 64'h1);
      rdchk("R9 wfix cleared", 16'h80D0, 64'h0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule